// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Dispatcher

This block sits between two in-order issue slots and the register-access stages of three integer-side execution pipes: a complex integer pipe, a simple integer pipe and a load/store pipe. On each cycle it looks at the instruction class in each valid slot. It picks a pipe whose register-access stage is empty, or is emptying in that same cycle, and latches the instruction there. When it cannot place an instruction, it raises a stall back to that slot.

An instruction waits in its register-access stage until two conditions hold at once: an external scoreboard marks its operands ready, and the pipe beyond it reports not busy. On that cycle the block pulses the pipe's dispatch strobe and presents the class on that pipe's class output. The store-conditional class is special. It takes the load/store and complex stages together and leaves both of them in one cycle. It is accepted only from slot 0.

Pipe indices are fixed: 0 is the complex pipe, 1 is the simple pipe and 2 is the load/store pipe. Every per-pipe bus follows this order, with the lowest index in the least significant position.

Top module: `dsp_pipe_steer`

## Requirements
- R1: While reset is held, and right after it is released, all three stages are empty. No dispatch strobe rises even with every ready input high and busy low, and a valid slot is never stalled for lack of room.
- R2: Classes 0 to 3 (ALU, compare, shift, rotate) are flexible. They go to the simple pipe (index 1) if its stage is free, otherwise to the complex pipe (index 0). If neither stage is free, the slot stalls.
- R3: Classes 4 to 9 (multiply, divide, trap, branch, condition-register move, special register) and the unassigned codes 14 and 15 go only to the complex pipe. The slot stalls while that stage is not free.
- R4: Classes 10 to 12 (load, store, cache management) go only to the load/store pipe (index 2). The slot stalls while that stage is not free.
- R5: An accepted instruction is held in its stage. It dispatches in the first cycle after acceptance in which its pipe's ready input is 1 and its busy input is 0. The strobe rises in that cycle and the class appears on the class output; the strobe never rises in the cycle of acceptance.
- R6: Class 13 (store-conditional) from slot 0 is accepted only when the complex and load/store stages are both free, and it occupies both. Both strobes rise together, and only in a cycle where both pipes are ready and not busy.
- R7: Class 13 in slot 1 is never accepted; slot 1 stalls.
- R8: When both slots need the same single pipe, slot 0 gets it and slot 1 stalls.
- R9: A flexible instruction in slot 0 takes the simple pipe when both integer stages are free. This leaves the complex stage for slot 1 in the same cycle.
- R10: When slot 0 is valid and stalled, slot 1 also stalls, even if a suitable stage is free.
- R11: A stage that dispatches in a cycle can accept a new instruction in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_vld_i | input | 1 | Slot 0 holds an instruction |
| s0_cls_i | input | 4 | Slot 0 instruction class code |
| s1_vld_i | input | 1 | Slot 1 holds an instruction |
| s1_cls_i | input | 4 | Slot 1 instruction class code |
| pipe_rdy_i | input | 3 | Per pipe: operands of the held instruction are ready |
| pipe_busy_i | input | 3 | Per pipe: the stage beyond cannot take an instruction |
| disp_o | output | 3 | Per pipe dispatch strobe |
| disp_cls_o | output | 12 | Per pipe class of the dispatching instruction, 4 bits per pipe, 0 when idle |
| s0_stall_o | output | 1 | Slot 0 instruction not accepted this cycle |
| s1_stall_o | output | 1 | Slot 1 instruction not accepted this cycle |

## Verification
A stage wrongly left occupied shows up at the slot stall outputs in the very next cycle: an instruction that should be placed stalls. A stage wrongly marked empty shows up as a missing dispatch strobe once ready is raised. A steering fault, such as a flexible class sent to the complex pipe or a memory class sent anywhere but the load/store pipe, appears one cycle after acceptance on the wrong bit of the strobe and class buses. Errors in pair tracking for the store-conditional class appear as a lone strobe on one of its two pipes, or as a stage that never empties.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int CLS_W   = 4;
    localparam int NPIPE   = 3;
    localparam int PIPE_CX = 0;
    localparam int PIPE_SX = 1;
    localparam int PIPE_LS = 2;

    // class codes
    localparam logic [CLS_W-1:0] CL_ALU   = CLS_W'(0);
    localparam logic [CLS_W-1:0] CL_ROT   = CLS_W'(3);
    localparam logic [CLS_W-1:0] CL_LOAD  = CLS_W'(10);
    localparam logic [CLS_W-1:0] CL_CACHE = CLS_W'(12);
    localparam logic [CLS_W-1:0] CL_ATOM  = CLS_W'(13);

    typedef enum logic [1:0] {
        RT_FLEX,
        RT_CX,
        RT_LS,
        RT_PAIR
    } route_e;

    typedef struct packed {
        logic             occ;
        logic [CLS_W-1:0] cls;
        logic             pair;
    } stage_t;

    function automatic route_e route_of(input logic [CLS_W-1:0] c);
        route_e r;
        if (c <= CL_ROT)
            r = RT_FLEX;
        else if (c >= CL_LOAD && c <= CL_CACHE)
            r = RT_LS;
        else if (c == CL_ATOM)
            r = RT_PAIR;
        else
            r = RT_CX;
        return r;
    endfunction

    // one-hot (or pair) target for a route given the free stages; zero if none fits
    function automatic logic [NPIPE-1:0] pick_target(input route_e r,
                                                     input logic [NPIPE-1:0] f);
        logic [NPIPE-1:0] t;
        t = '0;
        case (r)
            RT_FLEX: begin
                if (f[PIPE_SX])      t[PIPE_SX] = 1'b1;
                else if (f[PIPE_CX]) t[PIPE_CX] = 1'b1;
            end
            RT_CX:   if (f[PIPE_CX]) t[PIPE_CX] = 1'b1;
            RT_LS:   if (f[PIPE_LS]) t[PIPE_LS] = 1'b1;
            default: begin
                if (f[PIPE_CX] && f[PIPE_LS]) begin
                    t[PIPE_CX] = 1'b1;
                    t[PIPE_LS] = 1'b1;
                end
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dsp_ra_stage.sv
module dsp_ra_stage
    import dsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CLS_W-1:0] load_cls_i,
    input  logic             load_pair_i,
    input  logic             go_i,
    output logic             occ_o,
    output logic [CLS_W-1:0] cls_o,
    output logic             pair_o
);

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (go_i) begin
            st_d.occ  = 1'b0;
            st_d.pair = 1'b0;
        end
        if (load_i) begin
            st_d.occ  = 1'b1;
            st_d.cls  = load_cls_i;
            st_d.pair = load_pair_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ_o  = st_q.occ;
    assign cls_o  = st_q.cls;
    assign pair_o = st_q.pair;

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!st_q.occ || go_i)); // R11

    AST_HOLD_UNTIL_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.occ && !go_i) |=> (st_q.occ && $stable(st_q.cls))); // R5

    AST_NO_GO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> st_q.occ); // R5

endmodule

// File: rtl/dsp_steer.sv
module dsp_steer
    import dsp_pkg::*;
(
    input  logic             s0_vld_i,
    input  logic [CLS_W-1:0] s0_cls_i,
    input  logic             s1_vld_i,
    input  logic [CLS_W-1:0] s1_cls_i,
    input  logic [NPIPE-1:0] free_i,
    output logic             acc0_o,
    output logic             acc1_o,
    output logic [NPIPE-1:0] tgt0_o,
    output logic [NPIPE-1:0] tgt1_o
);

    route_e           r0, r1;
    logic [NPIPE-1:0] left;
    logic [NPIPE-1:0] t1_raw;

    always_comb begin
        r0     = route_of(s0_cls_i);
        r1     = route_of(s1_cls_i);
        tgt0_o = s0_vld_i ? pick_target(r0, free_i) : '0;
        acc0_o = |tgt0_o;
        left   = free_i & ~tgt0_o;
        // slot 1 never takes the paired class, and never passes a stalled slot 0
        t1_raw = (s1_vld_i && r1 != RT_PAIR) ? pick_target(r1, left) : '0;
        acc1_o = (|t1_raw) && (!s0_vld_i || acc0_o);
        tgt1_o = acc1_o ? t1_raw : '0;
    end

endmodule

// File: rtl/dsp_pipe_steer.sv
module dsp_pipe_steer
    import dsp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s0_vld_i,
    input  logic [CLS_W-1:0]       s0_cls_i,
    input  logic                   s1_vld_i,
    input  logic [CLS_W-1:0]       s1_cls_i,
    input  logic [NPIPE-1:0]       pipe_rdy_i,
    input  logic [NPIPE-1:0]       pipe_busy_i,
    output logic [NPIPE-1:0]       disp_o,
    output logic [NPIPE*CLS_W-1:0] disp_cls_o,
    output logic                   s0_stall_o,
    output logic                   s1_stall_o
);

    logic [NPIPE-1:0] occ, pair, own_go, go, free, load, load_pair;
    logic [CLS_W-1:0] cls      [NPIPE];
    logic [CLS_W-1:0] load_cls [NPIPE];
    logic             pair_go, acc0, acc1;
    logic [NPIPE-1:0] tgt0, tgt1;
    route_e           r0;

    always_comb begin
        r0      = route_of(s0_cls_i);
        own_go  = occ & pipe_rdy_i & ~pipe_busy_i;
        pair_go = own_go[PIPE_CX] && own_go[PIPE_LS];
        for (int p = 0; p < NPIPE; p++) begin
            go[p] = pair[p] ? pair_go : own_go[p];
        end
        free = ~occ | go;
    end

    dsp_steer u_steer (
        .s0_vld_i (s0_vld_i),
        .s0_cls_i (s0_cls_i),
        .s1_vld_i (s1_vld_i),
        .s1_cls_i (s1_cls_i),
        .free_i   (free),
        .acc0_o   (acc0),
        .acc1_o   (acc1),
        .tgt0_o   (tgt0),
        .tgt1_o   (tgt1)
    );

    for (genvar p = 0; p < NPIPE; p++) begin : g_ra
        always_comb begin
            load[p]      = tgt0[p] | tgt1[p];
            load_cls[p]  = tgt0[p] ? s0_cls_i : s1_cls_i;
            load_pair[p] = tgt0[p] && (r0 == RT_PAIR);
        end

        dsp_ra_stage u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load[p]),
            .load_cls_i  (load_cls[p]),
            .load_pair_i (load_pair[p]),
            .go_i        (go[p]),
            .occ_o       (occ[p]),
            .cls_o       (cls[p]),
            .pair_o      (pair[p])
        );

        assign disp_cls_o[p*CLS_W +: CLS_W] = go[p] ? cls[p] : '0;
    end

    assign disp_o     = go;
    assign s0_stall_o = s0_vld_i && !acc0;
    assign s1_stall_o = s1_vld_i && !acc1;

    AST_PAIR_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_o[PIPE_CX] && disp_cls_o[PIPE_CX*CLS_W +: CLS_W] == CL_ATOM)
        |-> (disp_o[PIPE_LS] && disp_cls_o[PIPE_LS*CLS_W +: CLS_W] == CL_ATOM)); // R6

    AST_SLOT1_NO_ATOM: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld_i && s1_cls_i == CL_ATOM) |-> s1_stall_o); // R7

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        s0_stall_o |-> (!s1_vld_i || s1_stall_o)); // R10

    AST_NO_DUAL_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0 && acc1) |-> ((tgt0 & tgt1) == '0)); // R8

    AST_MEM_TO_LS: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld_i && !s0_stall_o && route_of(s0_cls_i) == RT_LS)
        |=> (occ[PIPE_LS] && cls[PIPE_LS] == $past(s0_cls_i))); // R4

    AST_CX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld_i && !s0_stall_o && route_of(s0_cls_i) == RT_CX)
        |=> (occ[PIPE_CX] && cls[PIPE_CX] == $past(s0_cls_i))); // R3

endmodule

// File: tb/sim_dsp_pipe_steer.sv
`timescale 1ns/1ps
module sim_dsp_pipe_steer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s0_vld = 1'b0, s1_vld = 1'b0;
    logic [3:0]  s0_cls = '0, s1_cls = '0;
    logic [2:0]  rdy = '0, busy = '0;
    logic [2:0]  disp;
    logic [11:0] dcls;
    logic        st0, st1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dsp_pipe_steer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .s0_vld_i    (s0_vld),
        .s0_cls_i    (s0_cls),
        .s1_vld_i    (s1_vld),
        .s1_cls_i    (s1_cls),
        .pipe_rdy_i  (rdy),
        .pipe_busy_i (busy),
        .disp_o      (disp),
        .disp_cls_o  (dcls),
        .s0_stall_o  (st0),
        .s1_stall_o  (st1)
    );

    // {v0, c0, v1, c1, stall0, stall1, dispatch mask, class LS, class SX, class CX}
    localparam int NV = 15;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 4'd0,  1'b0, 4'd0,  1'b0, 1'b0, 3'b010, 4'd0,  4'd0, 4'd0 },
        {1'b1, 4'd0,  1'b1, 4'd1,  1'b0, 1'b0, 3'b011, 4'd0,  4'd0, 4'd1 },
        {1'b1, 4'd4,  1'b1, 4'd2,  1'b0, 1'b0, 3'b011, 4'd0,  4'd2, 4'd4 },
        {1'b1, 4'd5,  1'b1, 4'd7,  1'b0, 1'b1, 3'b001, 4'd0,  4'd0, 4'd5 },
        {1'b1, 4'd10, 1'b1, 4'd3,  1'b0, 1'b0, 3'b110, 4'd10, 4'd3, 4'd0 },
        {1'b1, 4'd11, 1'b1, 4'd12, 1'b0, 1'b1, 3'b100, 4'd11, 4'd0, 4'd0 },
        {1'b1, 4'd13, 1'b1, 4'd0,  1'b0, 1'b0, 3'b111, 4'd13, 4'd0, 4'd13},
        {1'b1, 4'd13, 1'b1, 4'd4,  1'b0, 1'b1, 3'b101, 4'd13, 4'd0, 4'd13},
        {1'b1, 4'd0,  1'b1, 4'd13, 1'b0, 1'b1, 3'b010, 4'd0,  4'd0, 4'd0 },
        {1'b0, 4'd0,  1'b1, 4'd13, 1'b0, 1'b1, 3'b000, 4'd0,  4'd0, 4'd0 },
        {1'b0, 4'd0,  1'b1, 4'd9,  1'b0, 1'b0, 3'b001, 4'd0,  4'd0, 4'd9 },
        {1'b1, 4'd6,  1'b1, 4'd10, 1'b0, 1'b0, 3'b101, 4'd10, 4'd0, 4'd6 },
        {1'b1, 4'd8,  1'b1, 4'd0,  1'b0, 1'b0, 3'b011, 4'd0,  4'd0, 4'd8 },
        {1'b1, 4'd15, 1'b0, 4'd0,  1'b0, 1'b0, 3'b001, 4'd0,  4'd0, 4'd15},
        {1'b1, 4'd12, 1'b1, 4'd1,  1'b0, 1'b0, 3'b110, 4'd12, 4'd1, 4'd0 }
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step(input logic v0, input logic [3:0] c0,
                        input logic v1, input logic [3:0] c1,
                        input logic [2:0] r, input logic [2:0] b);
        @(negedge clk);
        s0_vld = v0; s0_cls = c0; s1_vld = v1; s1_cls = c1;
        rdy = r; busy = b;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rdy = 3'b111;
        s0_vld = 1'b1; s0_cls = 4'd0;
        #9;
        check({29'd0, disp}, 32'd0, "R1 no dispatch in reset");
        check({31'd0, st0}, 32'd0, "R1 no stall in reset");
        s0_vld = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
        check({29'd0, disp}, 32'd0, "R1 empty after release");

        // steering vectors: R2 R3 R4 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            step(v[26], v[25:22], v[21], v[20:17], 3'b000, 3'b000);
            check({30'd0, st0, st1}, {30'd0, v[16], v[15]}, $sformatf("R8 R7 R10 stalls vector %0d", i));
            step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
            check({29'd0, disp}, {29'd0, v[14:12]}, $sformatf("R2 R3 R4 R6 R9 mask vector %0d", i));
            check({20'd0, dcls}, {20'd0, v[11:0]}, $sformatf("R2 R3 R4 R6 class vector %0d", i));
            step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);
        end

        // R5: hold until ready and not busy
        step(1'b1, 4'd1, 1'b0, 4'd0, 3'b111, 3'b000);
        check({29'd0, disp}, 32'd0, "R5 no dispatch in accept cycle");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);
        check({29'd0, disp}, 32'd0, "R5 held while not ready");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b010);
        check({29'd0, disp}, 32'd0, "R5 held while busy");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
        check({29'd0, disp}, 32'h2, "R5 dispatch when ready");
        check({20'd0, dcls}, 32'h010, "R5 dispatched class");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
        check({29'd0, disp}, 32'd0, "R5 stage emptied");

        // R10 and R2: complex stage held
        step(1'b1, 4'd5, 1'b0, 4'd0, 3'b000, 3'b000);
        step(1'b1, 4'd4, 1'b1, 4'd0, 3'b000, 3'b000);
        check({30'd0, st0, st1}, 32'h3, "R10 slot 1 waits behind stalled slot 0");
        step(1'b1, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);
        check({31'd0, st0}, 32'd0, "R2 flexible to simple pipe");
        step(1'b1, 4'd3, 1'b0, 4'd0, 3'b000, 3'b000);
        check({31'd0, st0}, 32'd1, "R2 flexible stalls when both full");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
        check({20'd0, dcls, 1'b0, disp}, {20'h005, 1'b0, 3'b011}, "R2 drain complex and simple");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);

        // R2: flexible to complex when simple is full
        step(1'b1, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);
        step(1'b1, 4'd1, 1'b0, 4'd0, 3'b000, 3'b000);
        check({31'd0, st0}, 32'd0, "R2 flexible to complex pipe");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
        check({20'd0, dcls, 1'b0, disp}, {20'h001, 1'b0, 3'b011}, "R2 complex got compare");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);

        // R11: reuse of a leaving stage
        step(1'b1, 4'd5, 1'b0, 4'd0, 3'b000, 3'b000);
        step(1'b1, 4'd4, 1'b0, 4'd0, 3'b001, 3'b000);
        check({20'd0, dcls, st0, disp}, {20'h005, 1'b0, 3'b001}, "R11 accept into leaving stage");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b001, 3'b000);
        check({20'd0, dcls, 1'b0, disp}, {20'h004, 1'b0, 3'b001}, "R11 new occupant dispatches");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);

        // R6: paired dispatch
        step(1'b1, 4'd13, 1'b0, 4'd0, 3'b000, 3'b000);
        check({31'd0, st0}, 32'd0, "R6 pair accepted");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b001, 3'b000);
        check({29'd0, disp}, 32'd0, "R6 complex half alone not enough");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b100, 3'b000);
        check({29'd0, disp}, 32'd0, "R6 memory half alone not enough");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b101, 3'b100);
        check({29'd0, disp}, 32'd0, "R6 blocked by busy");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b101, 3'b000);
        check({20'd0, dcls, 1'b0, disp}, {20'hD0D, 1'b0, 3'b101}, "R6 both halves together");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);
        step(1'b1, 4'd10, 1'b0, 4'd0, 3'b000, 3'b000);
        step(1'b1, 4'd13, 1'b0, 4'd0, 3'b000, 3'b000);
        check({31'd0, st0}, 32'd1, "R6 pair stalls with memory stage full");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b111, 3'b000);
        check({20'd0, dcls, 1'b0, disp}, {20'hA00, 1'b0, 3'b100}, "R4 load drained");
        step(1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule